// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

The arbiter collects five interrupt sources for a small CPU core: two external request lines, two timer overflow flags and one serial source. The serial source is the OR of a receive-complete flag and a transmit-complete flag. Each source passes only when its own enable bit and a global enable bit are both set. Each source also carries one priority bit, which places it at the low level or the high level.

Requests are sampled only on a machine-cycle strobe. When a request is accepted, the arbiter raises `irq_o` and presents the vector address of the winning source. Both stay unchanged until the CPU acknowledges them. On acknowledge, the arbiter records that the winner's priority level is in service. A high-level request may then interrupt a low-level routine, but nothing interrupts a high-level routine. Each return-from-interrupt pulse retires the highest level that is in service.

The serial vector is shared by receive and transmit, so the service routine must read both flags to find the cause.

Top module: `irq_arbiter`

## Requirements
- R1: After a synchronous reset, `irq_o` is 0, `svc_lvl_o` is 2'b00 and `vec_o` is 16'h0000.
- R2: The vector is 16'h0003 + 8×index, where the polling index is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. This gives 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R3: The serial source (index 4) requests when `ser_rx_i` or `ser_tx_i` is high. It is gated by enable bit 4.
- R4: A source takes part only when enable bit `ien_i[index]` and global enable `ien_i[7]` are both 1. Enable bits 5 and 6 have no effect.
- R5: If any competing source has its priority bit `ipri_i[index]` set, a high-level source wins over every low-level source.
- R6: Within one priority level, the lowest polling index wins.
- R7: Requests are evaluated only in a cycle where `tick_i` is high and no vector is pending. `irq_o` rises in the cycle after that evaluation.
- R8: While `irq_o` is high and `ack_i` is low, `irq_o` and `vec_o` hold their values. When `ack_i` is high, `irq_o` falls in the next cycle and the winner's level bit is set in `svc_lvl_o`. Bit 0 is the low level and bit 1 is the high level.
- R9: A low-level request is not accepted while any level is in service. A high-level request is accepted while only the low level is in service, and is not accepted while the high level is in service.
- R10: A `reti_i` pulse clears `svc_lvl_o[1]` if it is set, and otherwise clears `svc_lvl_o[0]`. When an acknowledge arrives in the same cycle, its bit is set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Machine-cycle strobe; requests are evaluated only when it is high |
| ext_req_i | input | 2 | External request levels; bit 0 is external 0 |
| tmr_ovf_i | input | 2 | Timer overflow flags; bit 0 is timer 0 |
| ser_rx_i | input | 1 | Serial receive-complete flag |
| ser_tx_i | input | 1 | Serial transmit-complete flag |
| ien_i | input | 8 | Enable register: bits 0–4 are per source in polling order, bit 7 is the global enable |
| ipri_i | input | 5 | Priority register: one bit per source in polling order, 1 = high level |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the pending source |
| svc_lvl_o | output | 2 | In-service levels: bit 0 low, bit 1 high |

## Verification
The bench aims at the case where a vector is pending and a better request arrives before the acknowledge. A design that re-arbitrates in that window would change `vec_o` under the CPU. It also drives a high-level request during low-level service, where a design with no preemption would stall, and a request during high-level service, where a design with too much preemption would nest. A `reti_i` with both levels in service checks that only the high bit clears; clearing both, or clearing the low bit, shows up as a wrong `svc_lvl_o`. Masking cases drop the global bit, a single enable bit or the serial bit, and a design that ignored any of them would raise `irq_o`.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NSRC     = 5;
    localparam int SRC_W    = $clog2(NSRC);
    localparam int N_EXT    = 2;
    localparam int N_TMR    = 2;
    localparam int EN_W     = 8;
    localparam int GIE_BIT  = 7;
    localparam int VEC_W    = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam logic [VEC_W-1:0] VEC_STEP = 16'h0008;

    // polling order; the index is also the enable and priority bit position
    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    typedef struct packed {
        logic             valid;
        lvl_e             lvl;
        logic [SRC_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic             vld;
        lvl_e             lvl;
        logic [VEC_W-1:0] vec;
    } pend_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_BASE + VEC_W'(idx) * VEC_STEP;
    endfunction

    function automatic logic [SRC_W-1:0] lowest_idx(input logic [NSRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate
    import irq_arb_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] src_en_i,
    input  logic         glob_en_i,
    input  logic [N-1:0] pri_i,
    output logic [N-1:0] act_hi_o,
    output logic [N-1:0] act_lo_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic live;
        assign live        = raw_i[g] & src_en_i[g] & glob_en_i;
        assign act_hi_o[g] = live & pri_i[g];
        assign act_lo_o[g] = live & ~pri_i[g];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0] act_hi_i,
    input  logic [NSRC-1:0] act_lo_i,
    input  logic [1:0]      svc_i,
    output pick_t           grant_o
);

    logic hi_any;
    logic lo_any;

    assign hi_any = |act_hi_i;
    assign lo_any = |act_lo_i;

    always_comb begin
        grant_o = '0;
        if (hi_any) begin
            grant_o.lvl   = LVL_HI;
            grant_o.idx   = lowest_idx(act_hi_i);
            grant_o.valid = ~svc_i[LVL_HI];
        end else begin
            grant_o.lvl   = LVL_LO;
            grant_o.idx   = lowest_idx(act_lo_i);
            grant_o.valid = lo_any & (svc_i == 2'b00);
        end
    end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_lo_i,
    input  logic       set_hi_i,
    input  logic       reti_i,
    output logic [1:0] svc_o
);

    logic [1:0] svc_q;
    logic [1:0] cleared;

    always_comb begin
        cleared = svc_q;
        if (reti_i) begin
            if (svc_q[1]) cleared[1] = 1'b0;
            else          cleared[0] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) svc_q <= 2'b00;
        else     svc_q <= cleared | {set_hi_i, set_lo_i};
    end

    assign svc_o = svc_q;

    // R10
    reti_top_only_chk: assert property (@(posedge clk) disable iff (rst)
        (reti_i && svc_q == 2'b11 && !set_lo_i && !set_hi_i) |=> (svc_q == 2'b01));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [N_EXT-1:0] ext_req_i,
    input  logic [N_TMR-1:0] tmr_ovf_i,
    input  logic             ser_rx_i,
    input  logic             ser_tx_i,
    input  logic [EN_W-1:0]  ien_i,
    input  logic [NSRC-1:0]  ipri_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [1:0]       svc_lvl_o
);

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] act_hi;
    logic [NSRC-1:0] act_lo;
    logic [1:0]      svc;
    pick_t           grant;
    pend_t           pend_q;
    logic            take;
    logic            unused_en_bits;

    assign unused_en_bits = ^ien_i[GIE_BIT-1:NSRC];

    // the serial flags share one source slot
    assign raw = {ser_rx_i | ser_tx_i, tmr_ovf_i[1], ext_req_i[1], tmr_ovf_i[0], ext_req_i[0]};

    irq_src_gate #(.N(NSRC)) u_gate (
        .raw_i     (raw),
        .src_en_i  (ien_i[NSRC-1:0]),
        .glob_en_i (ien_i[GIE_BIT]),
        .pri_i     (ipri_i),
        .act_hi_o  (act_hi),
        .act_lo_o  (act_lo)
    );

    irq_prio_pick u_pick (
        .act_hi_i (act_hi),
        .act_lo_i (act_lo),
        .svc_i    (svc),
        .grant_o  (grant)
    );

    assign take = pend_q.vld & ack_i;

    irq_svc_track u_svc (
        .clk      (clk),
        .rst      (rst),
        .set_lo_i (take & (pend_q.lvl == LVL_LO)),
        .set_hi_i (take & (pend_q.lvl == LVL_HI)),
        .reti_i   (reti_i),
        .svc_o    (svc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (take) begin
            pend_q.vld <= 1'b0;
        end else if (!pend_q.vld && tick_i && grant.valid) begin
            pend_q.vld <= 1'b1;
            pend_q.lvl <= grant.lvl;
            pend_q.vec <= vec_of(grant.idx);
        end
    end

    assign irq_o     = pend_q.vld;
    assign vec_o     = pend_q.vec;
    assign svc_lvl_o = svc;

    // R8
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

    // R7
    no_tick_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !tick_i) |=> !irq_o);

    // R9
    lo_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && pend_q.lvl == LVL_LO) |-> (svc == 2'b00));

    // R9
    hi_not_nested_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && pend_q.lvl == LVL_HI) |-> !svc[1]);

    // R4
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(ien_i[GIE_BIT]));

endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  ext = '0;
    logic [1:0]  tmr = '0;
    logic        rx = 1'b0;
    logic        tx = 1'b0;
    logic [7:0]  ien = '0;
    logic [4:0]  ipri = '0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq;
    logic [15:0] vec;
    logic [1:0]  svc;

    int total = 0;
    int fails = 0;

    // reference model state
    logic        m_irq = 1'b0;
    logic [15:0] m_vec = '0;
    logic        m_lvl = 1'b0;
    logic [1:0]  m_svc = '0;

    always #2 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .ext_req_i(ext), .tmr_ovf_i(tmr),
        .ser_rx_i(rx), .ser_tx_i(tx), .ien_i(ien), .ipri_i(ipri),
        .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec), .svc_lvl_o(svc)
    );

    task automatic expect_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R6 R9: expected winner from the requirements
    task automatic model_eval();
        logic [4:0] raw;
        logic [4:0] act;
        logic [4:0] hi;
        int win;
        logic wl;
        raw = {rx | tx, tmr[1], ext[1], tmr[0], ext[0]};
        for (int i = 0; i < 5; i++) act[i] = raw[i] & ien[i] & ien[7];
        hi  = act & ipri;
        win = -1;
        wl  = 1'b0;
        if (hi != 0) begin
            for (int i = 4; i >= 0; i--) if (hi[i]) win = i;
            wl = 1'b1;
            if (m_svc[1]) win = -1;
        end else if (act != 0) begin
            for (int i = 4; i >= 0; i--) if (act[i]) win = i;
            if (m_svc != 2'b00) win = -1;
        end
        if (win >= 0) begin
            m_irq = 1'b1;
            m_lvl = wl;
            m_vec = 16'(3 + 8 * win);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            logic [1:0] nsvc;
            @(posedge clk);
            if (rst) begin
                m_irq = 1'b0; m_vec = '0; m_svc = '0; m_lvl = 1'b0;
            end else begin
                nsvc = m_svc;
                if (reti) begin
                    if (nsvc[1]) nsvc[1] = 1'b0;
                    else         nsvc[0] = 1'b0;
                end
                if (m_irq && ack) begin
                    m_irq = 1'b0;
                    nsvc[m_lvl] = 1'b1;
                end else if (!m_irq && tick) begin
                    model_eval();
                end
                m_svc = nsvc;
            end
            #1;
            expect_eq("R7 irq", int'(irq), int'(m_irq));
            expect_eq("R2 vec", int'(vec), int'(m_vec));
            expect_eq("R10 svc", int'(svc), int'(m_svc));
            @(negedge clk);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; cyc(1); reti = 1'b0;
    endtask

    task automatic clear_reqs();
        ext = '0; tmr = '0; rx = 1'b0; tx = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(2);
        rst = 1'b0;
        // R1
        expect_eq("R1 irq", int'(irq), 0);
        expect_eq("R1 svc", int'(svc), 0);
        expect_eq("R1 vec", int'(vec), 0);

        tick = 1'b1; ien = 8'h9F; ipri = '0;
        // R2: each source alone
        for (int i = 0; i < 5; i++) begin
            clear_reqs();
            case (i)
                0: ext[0] = 1'b1;
                1: tmr[0] = 1'b1;
                2: ext[1] = 1'b1;
                3: tmr[1] = 1'b1;
                default: rx = 1'b1;
            endcase
            cyc(1);
            expect_eq("R2 vector", int'(vec), 3 + 8 * i);
            do_ack();
            clear_reqs();
            do_reti();
            cyc(1);
        end
        // R3: transmit flag alone, then serial enable bit cleared
        tx = 1'b1; cyc(1);
        expect_eq("R3 tx vector", int'(vec), 16'h0023);
        do_ack(); tx = 1'b0; do_reti();
        ien = 8'h8F; tx = 1'b1; rx = 1'b1; cyc(3);
        expect_eq("R3 masked", int'(irq), 0);
        clear_reqs(); ien = 8'h9F; cyc(1);
        // R4: global off, single enable off, bits 5 and 6 inert
        ien = 8'h1F; ext[0] = 1'b1; cyc(3);
        expect_eq("R4 global off", int'(irq), 0);
        ien = 8'h9E; cyc(3);
        expect_eq("R4 source off", int'(irq), 0);
        ien = 8'hFF; ext[0] = 1'b0; cyc(3);
        expect_eq("R4 spare bits", int'(irq), 0);
        ien = 8'h9F; ext[0] = 1'b1; cyc(1);
        expect_eq("R4 enabled", int'(irq), 1);
        do_ack(); clear_reqs(); do_reti(); cyc(1);
        // R6: ext0, ext1, tmr1 together at one level
        ext = 2'b11; tmr[1] = 1'b1; cyc(1);
        expect_eq("R6 first", int'(vec), 16'h0003);
        do_ack(); ext[0] = 1'b0; do_reti(); cyc(1);
        expect_eq("R6 second", int'(vec), 16'h0013);
        do_ack(); ext[1] = 1'b0; do_reti(); cyc(1);
        expect_eq("R6 third", int'(vec), 16'h001B);
        do_ack(); clear_reqs(); do_reti(); cyc(1);
        // R5: timer 1 raised to high level wins over all
        ipri = 5'b01000; ext = 2'b11; tmr = 2'b11; rx = 1'b1; cyc(1);
        expect_eq("R5 winner", int'(vec), 16'h001B);
        do_ack();
        expect_eq("R5 level", int'(svc), 2'b10);
        clear_reqs(); do_reti(); cyc(1);
        // R9: high preempts low, nothing preempts high
        ipri = 5'b00100; ext[0] = 1'b1; cyc(1); do_ack(); ext[0] = 1'b0;
        tmr[0] = 1'b1; cyc(3);
        expect_eq("R9 low blocked", int'(irq), 0);
        ext[1] = 1'b1; cyc(1);
        expect_eq("R9 preempt", int'(vec), 16'h0013);
        do_ack(); ext[1] = 1'b0;
        expect_eq("R9 both levels", int'(svc), 2'b11);
        ipri = 5'b01100; tmr[1] = 1'b1; cyc(3);
        expect_eq("R9 no nesting", int'(irq), 0);
        clear_reqs();
        // R10
        do_reti();
        expect_eq("R10 top cleared", int'(svc), 2'b01);
        do_reti();
        expect_eq("R10 low cleared", int'(svc), 2'b00);
        ipri = '0; cyc(1);
        // R7: no strobe, no issue
        tick = 1'b0; ext[0] = 1'b1; cyc(3);
        expect_eq("R7 no tick", int'(irq), 0);
        tick = 1'b1; cyc(1);
        expect_eq("R7 tick", int'(irq), 1);
        do_ack(); clear_reqs(); do_reti(); cyc(1);
        // R8: better request arrives while a vector waits
        ext[1] = 1'b1; cyc(1); ext[0] = 1'b1; ipri = 5'b00001; cyc(3);
        expect_eq("R8 held vec", int'(vec), 16'h0013);
        expect_eq("R8 held irq", int'(irq), 1);
        do_ack();
        expect_eq("R8 dropped", int'(irq), 0);
        clear_reqs(); ipri = '0; do_reti(); cyc(1);

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            tick = ($urandom % 3) != 0;
            ext  = 2'($urandom);
            tmr  = 2'($urandom);
            rx   = ($urandom % 4) == 0;
            tx   = ($urandom % 4) == 0;
            ien  = 8'($urandom) | (($urandom % 5 != 0) ? 8'h80 : 8'h00);
            ipri = 5'($urandom);
            ack  = ($urandom % 3) == 0;
            reti = ($urandom % 6) == 0;
            cyc(1);
        end
        ack = 1'b0; reti = 1'b0;
        finish_run();
    end

endmodule